// File: doc/BRIEF.md
# Single-Accumulator Processor on a Shared Bus

This block is a small processor built around one accumulator. It holds a program and its data in an internal word memory. It steps through each instruction in fixed phases: fetch the word, decode it, resolve the operand address, then execute. It repeats this until it meets a halt instruction. Every move between registers, and every memory read or write, goes over one shared data bus. A three-bit source code selects what drives that bus in each cycle. The registers are the program counter, address register, instruction register, data register, accumulator, temporary register, a carry flag, and an input register and an output register.

The host holds `rst` high and preloads memory through the program-load port. It may also place a word in the input register. It then releases reset and waits for `halted`. Results appear on the accumulator, carry and output-register ports. Each write to the output register produces a one-cycle strobe.

An instruction word is 16 bits: bit 15 is the indirect flag, bits 14:12 are the opcode and bits 11:0 are the address or immediate field. Opcodes are 0 AND, 1 ADD, 2 load, 3 store, 4 add-immediate, 5 no-operation, 6 register/IO group and 7 halt. Bus source codes are 0 zero, 1 address register, 2 program counter, 3 data register, 4 accumulator, 5 instruction register, 6 temporary register and 7 the memory word at the address register.

Top module: `acc_cpu`

## Requirements
- R1: A cycle with `rst` high clears the program counter, accumulator, carry flag, `halted` and `out_stb`, so all of them read zero in the first cycle after reset is released.
- R2: Opcode 2 with bit 15 clear loads the accumulator with the memory word at the address in bits 11:0.
- R3: When bit 15 is set, the word read at bits 11:0 provides the effective address in its low 12 bits, and the operand comes from that address.
- R4: Opcode 1 adds the memory operand to the accumulator modulo 2^16 and writes the carry out of bit 15 into the carry flag.
- R5: Opcode 0 replaces the accumulator with its bitwise AND with the memory operand and leaves the carry flag unchanged.
- R6: Opcode 3 writes the accumulator to the effective address, with the indirect flag honoured, so that a later load of that address returns it.
- R7: Opcode 4 adds bits 11:0, zero-extended to 16 bits, to the accumulator and writes the carry out into the carry flag.
- R8: In opcode 6, sub-code bit 0 loads the accumulator from the input register. Sub-code bit 1 copies the accumulator to `outr` and pulses `out_stb` high for exactly one cycle.
- R9: In opcode 6, only the lowest set bit among bits 3:0 acts. Bit 2 copies the accumulator into the temporary register, and bit 3 copies the temporary register into the accumulator.
- R10: Opcode 7 raises `halted`, which stays high until reset. While it is high the program counter, accumulator and carry hold, and no memory write occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_we | input | 1 | Write enable of the program-load port |
| prog_addr | input | 12 | Program-load word address |
| prog_data | input | 16 | Program-load word |
| in_wr | input | 1 | Loads `in_data` into the input register |
| in_data | input | 16 | Input-register data |
| outr | output | 16 | Output register |
| out_stb | output | 1 | One-cycle pulse after each output-register write |
| acc_o | output | 16 | Accumulator |
| e_o | output | 1 | Carry flag |
| pc_o | output | 12 | Program counter |
| halted | output | 1 | High after a halt instruction until reset |

## Verification
The bench builds the block with its default 12-bit address field, which gives 16-bit words and the full 4096-word memory. It runs small programs that sweep eight operand corners pairwise through add and AND: zero, one, both sign boundaries, all-ones and mixed patterns. It also sweeps immediates up to the 12-bit limit. These sweeps reach the carry out at 0xFFFF+1, wraparound to zero, and the full 12-bit zero-extension. Expected sums and carries are computed arithmetically in the bench. Other programs cover indirect store and load through pointer words, the IO sub-code priority, the temporary-register round trip, and the frozen state after a halt.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_AR   = 3'd1,
    SRC_PC   = 3'd2,
    SRC_DR   = 3'd3,
    SRC_AC   = 3'd4,
    SRC_IR   = 3'd5,
    SRC_TR   = 3'd6,
    SRC_MEM  = 3'd7
  } bus_src_e;

  typedef enum logic [2:0] {
    OP_AND  = 3'd0,
    OP_ADD  = 3'd1,
    OP_LDA  = 3'd2,
    OP_STA  = 3'd3,
    OP_ADDI = 3'd4,
    OP_NOP  = 3'd5,
    OP_IO   = 3'd6,
    OP_HALT = 3'd7
  } opcode_e;

  typedef enum logic [1:0] {
    ALU_AND  = 2'd0,
    ALU_ADD  = 2'd1,
    ALU_PASS = 2'd2
  } alu_op_e;

  typedef struct packed {
    bus_src_e sel;
    logic     ar_ld;
    logic     pc_inc;
    logic     ir_ld;
    logic     dr_ld;
    logic     dr_imm;
    logic     ac_ld_alu;
    logic     ac_ld_bus;
    logic     ac_ld_inp;
    logic     e_ld;
    logic     tr_ld;
    logic     outr_ld;
    logic     mem_we;
    logic     halt_set;
    alu_op_e  alu;
  } ctrl_t;

endpackage

// File: rtl/acc_cpu_bus.sv
module acc_cpu_bus
  import acc_cpu_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = AW + 4
) (
  input  bus_src_e        sel,
  input  logic [AW-1:0]   ar,
  input  logic [AW-1:0]   pc,
  input  logic [DW-1:0]   dr,
  input  logic [DW-1:0]   ac,
  input  logic [DW-1:0]   ir,
  input  logic [DW-1:0]   tr,
  input  logic [DW-1:0]   mem,
  output logic [DW-1:0]   bus
);
  localparam int PADW = DW - AW;

  always_comb begin
    case (sel)
      SRC_AR:  bus = {{PADW{1'b0}}, ar};
      SRC_PC:  bus = {{PADW{1'b0}}, pc};
      SRC_DR:  bus = dr;
      SRC_AC:  bus = ac;
      SRC_IR:  bus = ir;
      SRC_TR:  bus = tr;
      SRC_MEM: bus = mem;
      default: bus = '0;
    endcase
  end
endmodule

// File: rtl/acc_cpu_mem.sv
module acc_cpu_mem #(
  parameter int AW = 12,
  parameter int DW = AW + 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];
endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
  import acc_cpu_pkg::*;
#(
  parameter int DW = 16
) (
  input  alu_op_e       op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] res,
  output logic          carry
);
  logic [DW:0] sum;

  assign sum = {1'b0, a} + {1'b0, b};

  always_comb begin
    carry = 1'b0;
    case (op)
      ALU_AND: res = a & b;
      ALU_ADD: begin
        res   = sum[DW-1:0];
        carry = sum[DW];
      end
      default: res = b;
    endcase
  end
endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
  import acc_cpu_pkg::*;
#(
  parameter int SCW = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       mode,
  input  logic [2:0] op_bits,
  input  logic [3:0] sub,
  output ctrl_t      c,
  output logic       halted
);
  localparam logic [SCW-1:0] T0 = SCW'(0);
  localparam logic [SCW-1:0] T1 = SCW'(1);
  localparam logic [SCW-1:0] T2 = SCW'(2);
  localparam logic [SCW-1:0] T3 = SCW'(3);
  localparam logic [SCW-1:0] T4 = SCW'(4);
  localparam logic [SCW-1:0] T5 = SCW'(5);

  logic [SCW-1:0] sc;
  opcode_e        op;
  logic           last;

  assign op = opcode_e'(op_bits);

  always_comb begin
    c     = '0;
    c.sel = SRC_NONE;
    c.alu = ALU_PASS;
    last  = 1'b0;
    if (!halted) begin
      case (sc)
        T0: begin c.sel = SRC_PC;  c.ar_ld = 1'b1; end
        T1: begin c.sel = SRC_MEM; c.ir_ld = 1'b1; c.pc_inc = 1'b1; end
        T2: begin c.sel = SRC_IR;  c.ar_ld = 1'b1; end
        T3: if (mode) begin c.sel = SRC_MEM; c.ar_ld = 1'b1; end
        T4: begin
          case (op)
            OP_AND, OP_ADD, OP_LDA: begin c.sel = SRC_MEM; c.dr_ld = 1'b1; end
            OP_ADDI: begin c.sel = SRC_IR; c.dr_ld = 1'b1; c.dr_imm = 1'b1; end
            OP_STA:  begin c.sel = SRC_AC; c.mem_we = 1'b1; last = 1'b1; end
            OP_IO: begin
              last = 1'b1;
              if (sub[0])      c.ac_ld_inp = 1'b1;
              else if (sub[1]) begin c.sel = SRC_AC; c.outr_ld = 1'b1; end
              else if (sub[2]) begin c.sel = SRC_AC; c.tr_ld = 1'b1; end
              else if (sub[3]) begin c.sel = SRC_TR; c.ac_ld_bus = 1'b1; end
            end
            OP_HALT: c.halt_set = 1'b1;
            default: last = 1'b1;
          endcase
        end
        T5: begin
          last        = 1'b1;
          c.ac_ld_alu = 1'b1;
          case (op)
            OP_AND:          c.alu = ALU_AND;
            OP_ADD, OP_ADDI: begin c.alu = ALU_ADD; c.e_ld = 1'b1; end
            default:         c.alu = ALU_PASS;
          endcase
        end
        default: last = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sc     <= T0;
      halted <= 1'b0;
    end else begin
      if (c.halt_set) halted <= 1'b1;
      if (halted || c.halt_set) sc <= sc;
      else if (last)            sc <= T0;
      else                      sc <= sc + SCW'(1);
    end
  end
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = AW + 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          prog_we,
  input  logic [AW-1:0] prog_addr,
  input  logic [DW-1:0] prog_data,
  input  logic          in_wr,
  input  logic [DW-1:0] in_data,
  output logic [DW-1:0] outr,
  output logic          out_stb,
  output logic [DW-1:0] acc_o,
  output logic          e_o,
  output logic [AW-1:0] pc_o,
  output logic          halted
);
  localparam int PADW = DW - AW;

  ctrl_t         c;
  logic [AW-1:0] ar, pc;
  logic [DW-1:0] ir, dr, ac, tr, inpr;
  logic          e;
  logic [DW-1:0] bus, mem_rd, alu_res;
  logic          alu_carry;
  logic          cpu_we;
  logic          mem_we;
  logic [AW-1:0] mem_waddr;
  logic [DW-1:0] mem_wdata;

  acc_cpu_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .mode    (ir[DW-1]),
    .op_bits (ir[DW-2 -: 3]),
    .sub     (ir[3:0]),
    .c       (c),
    .halted  (halted)
  );

  acc_cpu_bus #(.AW(AW), .DW(DW)) u_bus (
    .sel (c.sel),
    .ar  (ar),
    .pc  (pc),
    .dr  (dr),
    .ac  (ac),
    .ir  (ir),
    .tr  (tr),
    .mem (mem_rd),
    .bus (bus)
  );

  assign cpu_we    = c.mem_we;
  assign mem_we    = cpu_we | prog_we;
  assign mem_waddr = cpu_we ? ar  : prog_addr;
  assign mem_wdata = cpu_we ? bus : prog_data;

  acc_cpu_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (ar),
    .rdata (mem_rd)
  );

  acc_cpu_alu #(.DW(DW)) u_alu (
    .op    (c.alu),
    .a     (ac),
    .b     (dr),
    .res   (alu_res),
    .carry (alu_carry)
  );

  always_ff @(posedge clk) begin
    if (c.ar_ld) ar <= bus[AW-1:0];
    if (c.ir_ld) ir <= bus;
    if (c.dr_ld) dr <= c.dr_imm ? {{PADW{1'b0}}, bus[AW-1:0]} : bus;
    if (c.tr_ld) tr <= bus;
    if (c.outr_ld) outr <= bus;
    if (in_wr) inpr <= in_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc      <= '0;
      ac      <= '0;
      e       <= 1'b0;
      out_stb <= 1'b0;
    end else begin
      out_stb <= c.outr_ld;
      if (c.pc_inc) pc <= pc + AW'(1);
      if (c.ac_ld_alu)      ac <= alu_res;
      else if (c.ac_ld_bus) ac <= bus;
      else if (c.ac_ld_inp) ac <= inpr;
      if (c.e_ld) e <= alu_carry;
    end
  end

  assign acc_o = ac;
  assign e_o   = e;
  assign pc_o  = pc;
endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk #(
  parameter int AW = 12,
  parameter int DW = AW + 4
) (
  input logic          clk,
  input logic          rst,
  input logic          halted,
  input logic          out_stb,
  input logic [AW-1:0] pc_o,
  input logic [DW-1:0] acc_o,
  input logic          e_o,
  input logic          mem_we
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pc_o == '0 && acc_o == '0 && !e_o && !halted && !out_stb));

  // R10
  halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  // R10
  halt_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> ($stable(pc_o) && $stable(acc_o) && $stable(e_o)));

  // R10
  halt_no_store_chk: assert property (@(posedge clk) disable iff (rst)
    halted |-> !mem_we);

  // R8
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    out_stb |=> !out_stb);
endmodule

bind acc_cpu acc_cpu_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .halted  (halted),
  .out_stb (out_stb),
  .pc_o    (pc_o),
  .acc_o   (acc_o),
  .e_o     (e_o),
  .mem_we  (cpu_we)
);

// File: tb/acc_cpu_tb.sv
`timescale 1ns/1ps
module acc_cpu_tb;
  localparam int AW = 12;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          prog_we = 1'b0;
  logic [AW-1:0] prog_addr = '0;
  logic [DW-1:0] prog_data = '0;
  logic          in_wr = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic [DW-1:0] outr;
  logic          out_stb;
  logic [DW-1:0] acc_o;
  logic          e_o;
  logic [AW-1:0] pc_o;
  logic          halted;

  int checks = 0;
  int errors = 0;
  int stb_cnt = 0;

  always #2.5 clk = ~clk;

  acc_cpu #(.AW(AW)) u_dut (
    .clk(clk), .rst(rst), .prog_we(prog_we), .prog_addr(prog_addr),
    .prog_data(prog_data), .in_wr(in_wr), .in_data(in_data),
    .outr(outr), .out_stb(out_stb), .acc_o(acc_o), .e_o(e_o),
    .pc_o(pc_o), .halted(halted)
  );

  always @(negedge clk) if (!rst && out_stb) stb_cnt++;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    prog_we = 1'b1; prog_addr = AW'(addr); prog_data = DW'(data);
    @(negedge clk);
    prog_we = 1'b0;
  endtask

  task automatic put_inp(input int data);
    @(negedge clk);
    in_wr = 1'b1; in_data = DW'(data);
    @(negedge clk);
    in_wr = 1'b0;
  endtask

  task automatic hold_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
  endtask

  task automatic run(input string req);
    int n = 0;
    stb_cnt = 0;
    @(negedge clk);
    rst = 1'b0;
    while (!halted && n < 400) begin
      @(negedge clk);
      n++;
    end
    chk(halted == 1'b1, req, "program halts", int'(halted), 1);
  endtask

  initial begin
    #(5.0 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] vals [8];
    logic [11:0] imms [6];
    vals = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234, 16'h00FF, 16'hAAAA};
    imms = '{12'h000, 12'h001, 12'hFFF, 12'h800, 12'h123, 12'h7FF};

    repeat (3) @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 state right after reset release
    chk(pc_o == 0 && acc_o == 0 && e_o == 0 && halted == 0 && out_stb == 0,
        "R1", "reset state", {pc_o, acc_o}, 0);

    // R4 add sweep (program: LDA 100, ADD 101, HALT)
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        int s;
        hold_reset();
        wr(0, 16'h2100); wr(1, 16'h1101); wr(2, 16'h7000);
        wr(12'h100, vals[i]); wr(12'h101, vals[j]);
        run("R4");
        s = int'(vals[i]) + int'(vals[j]);
        chk(acc_o == 16'(s), "R4", "sum", acc_o, s & 16'hFFFF);
        chk(e_o == s[16], "R4", "carry", e_o, s[16]);
      end
    end

    // R5 AND keeps E set from a prior carry
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        hold_reset();
        wr(0, 16'h2100); wr(1, 16'h1101); wr(2, 16'h2102); wr(3, 16'h0103); wr(4, 16'h7000);
        wr(12'h100, 16'hFFFF); wr(12'h101, 16'h0001);
        wr(12'h102, vals[i]); wr(12'h103, vals[j]);
        run("R5");
        chk(acc_o == (vals[i] & vals[j]), "R5", "and result", acc_o, vals[i] & vals[j]);
        chk(e_o == 1'b1, "R5", "carry kept", e_o, 1);
      end
    end

    // R7 immediate add sweep (LDA 100, ADDI k, HALT)
    for (int i = 0; i < 8; i++) begin
      for (int k = 0; k < 6; k++) begin
        int s;
        hold_reset();
        wr(0, 16'h2100); wr(1, {4'h4, imms[k]}); wr(2, 16'h7000);
        wr(12'h100, vals[i]);
        run("R7");
        s = int'(vals[i]) + int'(imms[k]);
        chk(acc_o == 16'(s), "R7", "imm sum", acc_o, s & 16'hFFFF);
        chk(e_o == s[16], "R7", "imm carry", e_o, s[16]);
      end
    end

    // R2 direct load returns the pointer word itself
    hold_reset();
    wr(0, 16'h2200); wr(1, 16'h7000); wr(12'h200, 16'h0250);
    run("R2");
    chk(acc_o == 16'h0250, "R2", "direct load", acc_o, 16'h0250);

    // R3 R6 indirect store then indirect load
    for (int i = 0; i < 8; i++) begin
      hold_reset();
      wr(0, 16'h2100); wr(1, 16'hB200); wr(2, 16'h2101); wr(3, 16'hA201); wr(4, 16'h7000);
      wr(12'h100, vals[i]); wr(12'h101, 16'h0000);
      wr(12'h200, 16'h0250); wr(12'h201, 16'h0250); wr(12'h250, 16'h5A5A);
      run("R6");
      chk(acc_o == vals[i], "R6", "indirect store/load", acc_o, vals[i]);
    end

    // R3 indirect load reaches the pointed word
    hold_reset();
    wr(0, 16'hA300); wr(1, 16'h7000); wr(12'h300, 16'hF310); wr(12'h310, 16'hC0DE);
    run("R3");
    chk(acc_o == 16'hC0DE, "R3", "pointer low 12 bits", acc_o, 16'hC0DE);

    // R8 input then output
    hold_reset();
    put_inp(16'hBEEF);
    wr(0, 16'h6001); wr(1, 16'h6002); wr(2, 16'h7000);
    run("R8");
    chk(acc_o == 16'hBEEF, "R8", "input to acc", acc_o, 16'hBEEF);
    chk(outr == 16'hBEEF, "R8", "output reg", outr, 16'hBEEF);
    chk(stb_cnt == 1, "R8", "strobe cycles", stb_cnt, 1);

    // R9 priority: sub-code 3 acts as input only
    hold_reset();
    put_inp(16'h1357);
    wr(0, 16'h2100); wr(1, 16'h6003); wr(2, 16'h7000); wr(12'h100, 16'h4444);
    run("R9");
    chk(acc_o == 16'h1357, "R9", "lowest bit wins", acc_o, 16'h1357);
    chk(stb_cnt == 0, "R9", "no output strobe", stb_cnt, 0);

    // R9 temporary register round trip
    hold_reset();
    wr(0, 16'h2100); wr(1, 16'h6004); wr(2, 16'h2101); wr(3, 16'h6008);
    wr(4, 16'h6002); wr(5, 16'h7000);
    wr(12'h100, 16'h9ABC); wr(12'h101, 16'h0000);
    run("R9");
    chk(acc_o == 16'h9ABC, "R9", "temp restore", acc_o, 16'h9ABC);
    chk(outr == 16'h9ABC && stb_cnt == 1, "R9", "temp to output", outr, 16'h9ABC);

    // R10 frozen after halt (halt at address 5 -> pc 6)
    chk(pc_o == 12'd6, "R10", "pc past halt", pc_o, 6);
    repeat (20) @(negedge clk);
    chk(halted == 1'b1, "R10", "halted sticky", halted, 1);
    chk(pc_o == 12'd6 && acc_o == 16'h9ABC, "R10", "state frozen", pc_o, 6);

    // R1 reset after halt
    hold_reset();
    rst = 1'b0;
    @(negedge clk);
    chk(halted == 0 && pc_o == 0 && acc_o == 0 && e_o == 0, "R1", "reset clears halt",
        {halted, pc_o}, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule